// File: doc/BRIEF.md
# Coded Stripe Pattern Generator

This block turns a raster scan position into the black or white value of a vertical stripe pattern used for structured-light depth capture. A projector shows a set of such patterns one after another, and a camera records each. The pixel's sequence of black and white values over the set identifies its column, so depth can be found by triangulation. The stripes are vertical, so every row of a frame is the same and only the column count matters.

The block keeps its own column and row counters, which advance by one pixel on each cycle that the pixel-enable input is high. On every cycle it registers one output pixel for the current position. The pixel value is one bit of the column number, either in plain binary or in reflected Gray code. The pattern index selects the bit, starting from the most significant. Pattern 0 therefore splits the array into two halves, and each later pattern halves every stripe again, down to stripes one pixel wide. An invert input gives the complementary pattern. An index past the end of the set gives a black pixel and raises an error flag. The one-bit value is also given as a full-scale 8-bit intensity. Line-end and frame-end markers go with the pixel stream.

Top module: `stripe_pattern_gen`

## Requirements
- R1: While reset is held, every output is zero. The first pixel presented after reset is column 0, row 0.
- R2: With code select low (binary), the pixel bit for pattern index k is bit (COL_W-1-k) of the column number, where COL_W = 10 for 854 columns. Pattern 0 is 0 below column 512 and 1 from 512 up. Pattern 9 toggles on every column. The row has no effect.
- R3: With code select high (Gray), the pixel bit for pattern k is bit (9-k) of column XOR (column >> 1).
- R4: In Gray mode, the 10-bit codes collected over patterns 0 to 9 for two adjacent columns differ in exactly one bit.
- R5: When the invert input is high and the index is valid, the pixel bit is the complement of the bit that R2 or R3 gives.
- R6: A pattern index of 10 or more gives pixel bit 0 and intensity 0 whatever the invert input, and sets the error flag. A valid index clears the flag. The flag is registered together with the pixel.
- R7: The intensity output is 255 when the pixel bit is 1 and 0 when it is 0.
- R8: Each enabled cycle presents the current column and then advances it. Line-end is high with column 853. The next column is then 0 and the row increments.
- R9: Frame-end is high only with the last column of the last row (row 479 by default). After it, both counters return to 0.
- R10: When pixel enable is low, the counters hold. Pixel-valid, line-end and frame-end are 0. The pixel for the held column is still presented, using the current index, code select and invert inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Present the current pixel and advance the raster |
| pat_idx | input | IDX_W (4) | Pattern number within the set |
| code_gray | input | 1 | 0 = binary column code, 1 = reflected Gray code |
| invert | input | 1 | Complement the pattern |
| pix_valid | output | 1 | Registered copy of pix_en for this pixel |
| pix_bit | output | 1 | Black (0) or white (1) value |
| pix_level | output | PIX_W (8) | Intensity, 0 or full scale |
| col_idx | output | COL_W (10) | Column of the presented pixel |
| row_idx | output | ROW_W (9) | Row of the presented pixel |
| line_end | output | 1 | Pixel is the last of its row |
| frame_end | output | 1 | Pixel is the last of the frame |
| idx_err | output | 1 | Pattern index is outside the set |

## Verification
On every cycle, the assertions check the raster rules. The column stays in range, the counters wrap at the last column and last row, and they hold while enable is low. They also check that frame-end implies line-end, that an index error always comes with a black pixel, and that the intensity is always zero or full scale. Only the bench's scenarios can show that the chosen bit is the correct one. That covers the binary and Gray bit order, the effect of invert, and the one-bit step between the Gray codes of adjacent columns, which needs a sweep of all patterns while the raster is held.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

   typedef enum logic {
      CODE_BIN  = 1'b0,
      CODE_GRAY = 1'b1
   } code_sel_e;

   typedef struct packed {
      logic valid;
      logic line_end;
      logic frame_end;
   } raster_mark_t;

endpackage

// File: rtl/raster_cnt.sv
module raster_cnt #(
   parameter int COLS  = 854,
   parameter int ROWS  = 480,
   localparam int COL_W = $clog2(COLS),
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [COL_W-1:0] col,
   output logic [ROW_W-1:0] row,
   output logic             last_col,
   output logic             last_row
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

   if (COLS < 2) begin : g_bad_cols
      $error("raster_cnt: COLS must be at least 2");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("raster_cnt: ROWS must be at least 2");
   end

   assign last_col = (col == COL_LAST);
   assign last_row = (row == ROW_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (step) begin
         if (last_col) begin
            col <= '0;
            row <= last_row ? '0 : row + 1'b1;
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      col <= COL_LAST && row <= ROW_LAST); // R8

   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step && last_col |=> col == '0); // R8

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step && last_col && last_row |=> row == '0); // R9

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(col) && $stable(row)); // R10

endmodule

// File: rtl/stripe_coder.sv
module stripe_coder
   import stripe_pkg::*;
#(
   parameter int CODE_W  = 10,
   parameter int NUM_PAT = CODE_W,
   parameter bit GRAY_EN = 1'b1,
   localparam int IDX_W  = $clog2(NUM_PAT + 1)
) (
   input  logic [CODE_W-1:0] col,
   input  logic [IDX_W-1:0]  idx,
   input  code_sel_e         sel,
   input  logic              inv,
   output logic              bit_out,
   output logic              idx_bad
);

   logic [CODE_W-1:0] code;
   logic              raw;

   if (NUM_PAT > CODE_W) begin : g_bad_pat
      $error("stripe_coder: NUM_PAT exceeds code width");
   end

   if (GRAY_EN) begin : g_gray
      logic [CODE_W-1:0] gray;
      assign gray = col ^ (col >> 1);
      assign code = (sel == CODE_GRAY) ? gray : col;
   end else begin : g_bin_only
      logic unused_sel;
      assign unused_sel = (sel == CODE_GRAY);
      assign code = col;
   end

   always_comb begin
      raw = 1'b0;
      for (int k = 0; k < NUM_PAT; k++) begin
         if (idx == IDX_W'(k)) raw = code[CODE_W-1-k];
      end
   end

   assign idx_bad = (idx >= IDX_W'(NUM_PAT));
   assign bit_out = idx_bad ? 1'b0 : (raw ^ inv);

endmodule

// File: rtl/level_expand.sv
module level_expand #(
   parameter int PIX_W = 8
) (
   input  logic             b,
   output logic [PIX_W-1:0] level
);

   if (PIX_W < 1) begin : g_bad_w
      $error("level_expand: PIX_W must be positive");
   end

   for (genvar i = 0; i < PIX_W; i++) begin : g_rep
      assign level[i] = b;
   end

endmodule

// File: rtl/stripe_pattern_gen.sv
module stripe_pattern_gen
   import stripe_pkg::*;
#(
   parameter int COLS    = 854,
   parameter int ROWS    = 480,
   parameter int PIX_W   = 8,
   parameter bit GRAY_EN = 1'b1,
   localparam int COL_W   = $clog2(COLS),
   localparam int ROW_W   = $clog2(ROWS),
   localparam int NUM_PAT = COL_W,
   localparam int IDX_W   = $clog2(NUM_PAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic [IDX_W-1:0] pat_idx,
   input  logic             code_gray,
   input  logic             invert,
   output logic             pix_valid,
   output logic             pix_bit,
   output logic [PIX_W-1:0] pix_level,
   output logic [COL_W-1:0] col_idx,
   output logic [ROW_W-1:0] row_idx,
   output logic             line_end,
   output logic             frame_end,
   output logic             idx_err
);

   logic [COL_W-1:0] col_c;
   logic [ROW_W-1:0] row_c;
   logic             last_col, last_row;
   logic             bit_c, bad_c;
   logic [PIX_W-1:0] level_c;
   code_sel_e        sel_c;
   raster_mark_t     mark_c, mark_q;

   assign sel_c = code_gray ? CODE_GRAY : CODE_BIN;

   raster_cnt #(.COLS(COLS), .ROWS(ROWS)) u_raster (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (pix_en),
      .col      (col_c),
      .row      (row_c),
      .last_col (last_col),
      .last_row (last_row)
   );

   stripe_coder #(.CODE_W(COL_W), .NUM_PAT(NUM_PAT), .GRAY_EN(GRAY_EN)) u_coder (
      .col     (col_c),
      .idx     (pat_idx),
      .sel     (sel_c),
      .inv     (invert),
      .bit_out (bit_c),
      .idx_bad (bad_c)
   );

   level_expand #(.PIX_W(PIX_W)) u_level (
      .b     (bit_c),
      .level (level_c)
   );

   assign mark_c.valid     = pix_en;
   assign mark_c.line_end  = pix_en & last_col;
   assign mark_c.frame_end = pix_en & last_col & last_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mark_q    <= '0;
         pix_bit   <= 1'b0;
         pix_level <= '0;
         col_idx   <= '0;
         row_idx   <= '0;
         idx_err   <= 1'b0;
      end else begin
         mark_q    <= mark_c;
         pix_bit   <= bit_c;
         pix_level <= level_c;
         col_idx   <= col_c;
         row_idx   <= row_c;
         idx_err   <= bad_c;
      end
   end

   assign pix_valid = mark_q.valid;
   assign line_end  = mark_q.line_end;
   assign frame_end = mark_q.frame_end;

   AST_ERR_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      idx_err |-> !pix_bit && pix_level == '0); // R6

   AST_LEVEL_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_level == '0 || pix_level == '1); // R7

   AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> line_end && row_idx == ROW_W'(ROWS - 1)); // R9

   AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |-> pix_valid && col_idx == COL_W'(COLS - 1)); // R8

endmodule

// File: tb/stripe_pattern_gen_tb.sv
module stripe_pattern_gen_tb;

   localparam int COLS  = 854;
   localparam int ROWS  = 4;
   localparam int COL_W = $clog2(COLS);
   localparam int ROW_W = $clog2(ROWS);
   localparam int NPAT  = COL_W;
   localparam int IDX_W = $clog2(NPAT + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pix_en = 1'b0;
   logic [IDX_W-1:0] pat_idx = '0;
   logic             code_gray = 1'b0;
   logic             invert = 1'b0;
   logic             pix_valid, pix_bit, line_end, frame_end, idx_err;
   logic [7:0]       pix_level;
   logic [COL_W-1:0] col_idx;
   logic [ROW_W-1:0] row_idx;

   int n_chk = 0, n_fail = 0;
   int m_col = 0, m_row = 0;
   bit done = 0;

   always #4 clk = ~clk;

   stripe_pattern_gen #(.COLS(COLS), .ROWS(ROWS)) u_dut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pat_idx(pat_idx),
      .code_gray(code_gray), .invert(invert), .pix_valid(pix_valid),
      .pix_bit(pix_bit), .pix_level(pix_level), .col_idx(col_idx),
      .row_idx(row_idx), .line_end(line_end), .frame_end(frame_end),
      .idx_err(idx_err)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (col %0d row %0d)", tag, act, exp, m_col, m_row);
      end
   endtask

   function automatic int ref_bit(int c, int k, bit g, bit inv);
      int code;
      if (k >= NPAT) return 0;
      code = g ? (c ^ (c >> 1)) : c;
      return ((code >> (NPAT - 1 - k)) & 1) ^ int'(inv);
   endfunction

   task automatic step(bit en, int k, bit g, bit inv);
      int e_bit, e_col, e_row, e_le, e_fe;
      string t;
      @(negedge clk);
      pix_en = en; pat_idx = IDX_W'(k); code_gray = g; invert = inv;
      e_bit = ref_bit(m_col, k, g, inv);
      e_col = m_col; e_row = m_row;
      e_le  = (en && m_col == COLS - 1) ? 1 : 0;
      e_fe  = (e_le == 1 && m_row == ROWS - 1) ? 1 : 0;
      if (en) begin
         if (m_col == COLS - 1) begin
            m_col = 0;
            m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
         end else m_col++;
      end
      @(posedge clk); #2;
      t = (k >= NPAT) ? "R6 black" : inv ? "R5 invert" : g ? "R3 gray" : "R2 binary";
      chk(t, int'(pix_bit), e_bit);
      chk("R6 err flag", int'(idx_err), (k >= NPAT) ? 1 : 0);
      chk("R7 level", int'(pix_level), e_bit ? 255 : 0);
      chk(en ? "R8 valid" : "R10 valid", int'(pix_valid), int'(en));
      chk(en ? "R8 column" : "R10 column", int'(col_idx), e_col);
      chk(en ? "R8 row" : "R10 row", int'(row_idx), e_row);
      chk("R8 line end", int'(line_end), e_le);
      chk("R9 frame end", int'(frame_end), e_fe);
   endtask

   task automatic gray_code_here(output int code);
      code = 0;
      for (int k = 0; k < NPAT; k++) begin
         step(1'b0, k, 1'b1, 1'b0);
         code = (code << 1) | int'(pix_bit);
      end
   endtask

   task automatic gray_adjacency(int count);
      int prev, cur;
      gray_code_here(prev);
      for (int i = 0; i < count; i++) begin
         step(1'b1, 0, 1'b1, 1'b0);
         gray_code_here(cur);
         chk("R4 gray one-bit step", $countones(prev ^ cur), 1);
         prev = cur;
      end
   endtask

   task automatic run_frame(int mode);
      int px = 0;
      while (px < COLS * ROWS) begin
         bit en = (mode == 4) ? ($urandom % 4 != 0) : 1'b1;
         int k  = (mode == 4) ? int'($urandom % 16) : int'($urandom % NPAT);
         bit g  = (mode == 4) ? bit'($urandom % 2) : bit'(mode % 2);
         bit iv = (mode == 4) ? bit'($urandom % 2) : bit'(mode / 2);
         step(en, k, g, iv);
         if (en) px++;
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1: outputs cleared during reset
      chk("R1 valid", int'(pix_valid), 0);
      chk("R1 bit", int'(pix_bit), 0);
      chk("R1 level", int'(pix_level), 0);
      chk("R1 col", int'(col_idx), 0);
      chk("R1 row", int'(row_idx), 0);
      chk("R1 marks", int'(line_end) + int'(frame_end) + int'(idx_err), 0);
      @(negedge clk); rst_n = 1'b1;
      step(1'b1, 0, 1'b0, 1'b0);           // R1 first pixel is column 0 row 0
      gray_adjacency(20);                  // R4 near the left edge
      for (int m = 0; m < 5; m++) run_frame(m);
      while (m_col != 505) step(1'b1, 9, 1'b0, 1'b0);
      gray_adjacency(12);                  // R4 across column 511/512
      for (int k = 10; k < 16; k++) step(1'b0, k, 1'b0, 1'b1);  // R6 with invert
      while (!(m_col == 0 && m_row == 0)) step(1'b1, 0, 1'b0, 1'b0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule